// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a bank of up to sixteen general-purpose input pins and turns selected pin activity into interrupt requests. Each pin can be set to trigger on a rising edge, a falling edge, both edges, a high level or a low level. A detected event sets a sticky pending bit for that pin. A per-pin mask keeps a pending bit from reaching the single shared interrupt line.

Software drives the block through a small register window. The window holds an enable register and a pair of write-one strobes, one that sets mask bits and one that clears them. It also holds a pending-status register whose bits are cleared by writing 1, and two mode registers that carry a 3-bit trigger code in each 4-bit nibble. Pin inputs are asynchronous, so they pass through a two-stage synchronizer before any event is detected.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset the enable, mask, pending status and every mode field are zero, every register reads 0, and `irq_out` is 0.
- R2: Word offset 4 holds the modes of pins 0 to 7 and offset 5 holds the modes of pins 8 to 15. Pin p uses bits [4k+2:4k] of its register, where k is p mod 8. Bit 4k+3 reads 0, and offsets 6 and 7 read 0.
- R3: Mode code 1 detects a rising edge, code 0 a falling edge and code 4 either edge. A pin change that is driven before clock edge k shows up in the pending status (offset 3) after edge k+2, and not before.
- R4: Mode code 3 (high level) and code 2 (low level) set the pending bit on every cycle the level is present. A clear made while the level persists leaves the bit set. A clear made after the level is gone leaves it at 0.
- R5: A pin whose enable bit (offset 0, read/write) is 0, or whose mode code is 5, 6 or 7, never sets its pending bit.
- R6: Writing a 1 to bit n of offset 3 clears pending bit n, and a 0 bit leaves it unchanged. When a clear and a new event reach the same pin on the same clock edge, the pending bit ends up set.
- R7: Writing a 1 to bit n of offset 1 masks pin n, and writing a 1 to bit n of offset 2 unmasks it. Zero bits change nothing, and reading either offset returns the current mask.
- R8: `irq_out` equals the OR over all pins of (pending AND NOT mask), delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Asynchronous pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with the default values, NPINS = 16 and AW = 3. With these values both mode registers are fully populated, so the lower-bank and upper-bank nibble decode can be tested, including pin 8 at the start of the second register. The 3-bit address also reaches the two unused offsets and the bank-1 register. Random writes put the reserved mode codes 5 to 7 and random enable patterns against random pin activity. Directed sequences cover the two-cycle synchronizer delay, a level that re-asserts after a clear, and a clear that lands on the same edge as a falling-edge event.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 16,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq_out
);

  localparam logic [AW-1:0] A_EN   = AW'(0);
  localparam logic [AW-1:0] A_MSET = AW'(1);
  localparam logic [AW-1:0] A_MCLR = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);
  localparam logic [AW-1:0] A_MOD0 = AW'(4);
  localparam logic [AW-1:0] A_MOD1 = AW'(5);
  localparam int PAD = 32 - NPINS;

  logic [NPINS-1:0] sync1, sync2, prev;
  logic [NPINS-1:0] en_q, mask_q, stat_q, hit, clr;
  logic [2:0]       mode_q [NPINS];
  logic [31:0]      mode_rd [2];

  wire wr_en   = reg_we && (reg_addr == A_EN);
  wire wr_mset = reg_we && (reg_addr == A_MSET);
  wire wr_mclr = reg_we && (reg_addr == A_MCLR);

  assign clr = (reg_we && reg_addr == A_STAT) ? reg_wdata[NPINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      mask_q  <= '0;
      stat_q  <= '0;
      irq_out <= 1'b0;
    end else begin
      if (wr_en)   en_q   <= reg_wdata[NPINS-1:0];
      if (wr_mset) mask_q <= mask_q | reg_wdata[NPINS-1:0];
      if (wr_mclr) mask_q <= mask_q & ~reg_wdata[NPINS-1:0];
      stat_q  <= (stat_q & ~clr) | hit;
      irq_out <= |(stat_q & ~mask_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPINS; p++) mode_q[p] <= 3'd0;
    end else if (reg_we) begin
      for (int p = 0; p < NPINS; p++)
        if (reg_addr == AW'(4 + p / 8)) mode_q[p] <= reg_wdata[4*(p%8) +: 3];
    end
  end

  always_comb begin
    mode_rd[0] = '0;
    mode_rd[1] = '0;
    for (int p = 0; p < NPINS; p++) mode_rd[p/8][4*(p%8) +: 3] = mode_q[p];
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic h;
    always_comb begin
      case (mode_q[g])
        3'd0:    h = ~sync2[g] & prev[g];
        3'd1:    h = sync2[g] & ~prev[g];
        3'd2:    h = ~sync2[g];
        3'd3:    h = sync2[g];
        3'd4:    h = sync2[g] ^ prev[g];
        default: h = 1'b0;
      endcase
    end
    assign hit[g] = en_q[g] & h;
  end

  always_comb begin
    case (reg_addr)
      A_EN:           reg_rdata = {{PAD{1'b0}}, en_q};
      A_MSET, A_MCLR: reg_rdata = {{PAD{1'b0}}, mask_q};
      A_STAT:         reg_rdata = {{PAD{1'b0}}, stat_q};
      A_MOD0:         reg_rdata = mode_rd[0];
      A_MOD1:         reg_rdata = mode_rd[1];
      default:        reg_rdata = '0;
    endcase
  end

endmodule

module gpio_irq_detect_chk #(
  parameter int NPINS = 16,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [AW-1:0]    reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             irq_out,
  input logic [NPINS-1:0] status,
  input logic [NPINS-1:0] mask,
  input logic [NPINS-1:0] enable
);

  logic [NPINS-1:0] wmask, clrw;
  assign wmask = reg_wdata[NPINS-1:0];
  assign clrw  = (reg_we && reg_addr == AW'(3)) ? wmask : '0;

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(|(status & ~mask)));

  assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(1)) |=> ((mask & $past(wmask)) == $past(wmask)));

  assert_mask_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(2)) |=> ((mask & $past(wmask)) == '0));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(status & ~clrw)) == $past(status & ~clrw)));

  assert_enable_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(enable)) == '0));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_out(irq_out), .status(stat_q),
  .mask(mask_q), .enable(en_q)
);

// File: tb/tb_gpio_irq_detect.sv
module tb_gpio_irq_detect;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_irq_detect #(.NPINS(N), .AW(3)) dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  logic [N-1:0] m_s1, m_s2, m_s3, m_en, m_mask, m_stat;
  logic [2:0]   m_mode [N];
  logic         m_irq;

  function automatic bit fire(logic [2:0] code, bit cur, bit old);
    case (code)
      3'd0: return !cur && old;
      3'd1: return cur && !old;
      3'd2: return !cur;
      3'd3: return cur;
      3'd4: return cur != old;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(logic [2:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      3'd0: v[N-1:0] = m_en;
      3'd1, 3'd2: v[N-1:0] = m_mask;
      3'd3: v[N-1:0] = m_stat;
      3'd4: for (int p = 0; p < 8; p++) v[4*p +: 3] = m_mode[p];
      3'd5: for (int p = 8; p < N; p++) v[4*(p-8) +: 3] = m_mode[p];
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string tag(logic [2:0] a);
    case (a)
      3'd0: return "R5";
      3'd1, 3'd2: return "R7";
      3'd3: return "R6";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_s3 <= '0;
      m_en <= '0; m_mask <= '0; m_stat <= '0; m_irq <= 1'b0;
      for (int p = 0; p < N; p++) m_mode[p] <= 3'd0;
    end else begin
      logic [N-1:0] ev, cl;
      for (int p = 0; p < N; p++) ev[p] = m_en[p] && fire(m_mode[p], m_s2[p], m_s3[p]);
      cl = (reg_we && reg_addr == 3'd3) ? reg_wdata[N-1:0] : '0;
      m_s1 <= pins; m_s2 <= m_s1; m_s3 <= m_s2;
      m_stat <= (m_stat & ~cl) | ev;
      m_irq <= |(m_stat & ~m_mask);
      if (reg_we) begin
        if (reg_addr == 3'd0) m_en <= reg_wdata[N-1:0];
        if (reg_addr == 3'd1) m_mask <= m_mask | reg_wdata[N-1:0];
        if (reg_addr == 3'd2) m_mask <= m_mask & ~reg_wdata[N-1:0];
        for (int p = 0; p < N; p++)
          if (reg_addr == 3'(4 + p / 8)) m_mode[p] <= reg_wdata[4*(p%8) +: 3];
      end
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit w, logic [2:0] a, logic [31:0] d, logic [N-1:0] pv);
    @(negedge clk);
    check(irq_out === m_irq, "R8", 32'(irq_out), 32'(m_irq));
    check(reg_rdata === exp_read(reg_addr), tag(reg_addr), reg_rdata, exp_read(reg_addr));
    reg_we = w; reg_addr = a; reg_wdata = d; pins = pv;
  endtask

  task automatic rdchk(logic [2:0] a, logic [31:0] exp, string req);
    step(1'b0, a, 32'h0, pins);
    #1;
    check(reg_rdata === exp, req, reg_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog expired, R1 to R8 incomplete actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) rdchk(3'(a), 32'h0, "R1");
    check(irq_out === 1'b0, "R1", 32'(irq_out), 32'h0);

    // R2 nibble layout, reserved bit reads 0
    step(1, 3'd4, 32'hFFFF_FFFF, '0);
    rdchk(3'd4, 32'h7777_7777, "R2");
    step(1, 3'd5, 32'h0000_0003, '0);
    rdchk(3'd5, 32'h0000_0003, "R2");
    rdchk(3'd6, 32'h0, "R2");

    // setup: p0 rise, p1 low, p2 high, p3 both, p4 code5, p8 fall
    step(1, 3'd4, 32'h0005_4321, '0);
    step(1, 3'd5, 32'h0, '0);
    step(1, 3'd0, 32'h0000_011F, '0);
    repeat (3) step(0, 3'd3, 0, '0);
    rdchk(3'd3, 32'h0000_0002, "R4");
    step(1, 3'd3, 32'hFFFF, '0);
    rdchk(3'd3, 32'h0000_0002, "R4");
    step(0, 3'd3, 0, 16'h0002);
    repeat (3) step(0, 3'd3, 0, 16'h0002);
    step(1, 3'd3, 32'hFFFF, 16'h0002);
    rdchk(3'd3, 32'h0, "R4");

    // R3 latency, R5 code 5 ignored
    step(0, 3'd3, 0, 16'h0013);
    rdchk(3'd3, 32'h0, "R3");
    rdchk(3'd3, 32'h0, "R3");
    rdchk(3'd3, 32'h0000_0001, "R3");
    rdchk(3'd3, 32'h0000_0001, "R5");
    check(irq_out === 1'b1, "R8", 32'(irq_out), 32'h1);

    // R7 mask set/clear
    step(1, 3'd1, 32'h0, pins);
    rdchk(3'd1, 32'h0, "R7");
    step(1, 3'd1, 32'h1, pins);
    rdchk(3'd2, 32'h1, "R7");
    step(0, 3'd3, 0, pins);
    #1 check(irq_out === 1'b0, "R8", 32'(irq_out), 32'h0);
    step(1, 3'd2, 32'h0, pins);
    rdchk(3'd1, 32'h1, "R7");
    step(1, 3'd2, 32'h1, pins);
    rdchk(3'd1, 32'h0, "R7");

    // R6 clear racing a falling edge on pin 8
    step(0, 3'd3, 0, 16'h0113);
    repeat (3) step(0, 3'd3, 0, 16'h0113);
    step(1, 3'd3, 32'hFFFF, 16'h0113);
    rdchk(3'd3, 32'h0, "R6");
    step(0, 3'd3, 0, 16'h0013);
    step(0, 3'd3, 0, 16'h0013);
    step(1, 3'd3, 32'h0100, 16'h0013);
    rdchk(3'd3, 32'h0000_0100, "R6");
    step(1, 3'd3, 32'h0, pins);
    rdchk(3'd3, 32'h0000_0100, "R6");
    step(1, 3'd3, 32'h0100, pins);
    rdchk(3'd3, 32'h0, "R6");

    // R5 enable off
    step(1, 3'd0, 32'h0, 16'h0013);
    step(0, 3'd3, 0, 16'h001B);
    repeat (3) step(0, 3'd3, 0, 16'h0012);
    rdchk(3'd3, 32'h0, "R5");

    // random phase, checked against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] pv;
      pv = pins;
      if ($urandom % 4 == 0) pv = N'($urandom);
      step(($urandom % 5) == 0, 3'($urandom), $urandom, pv);
    end
    repeat (4) step(0, 3'd3, 0, pins);
    finish_run();
  end
endmodule